// File: doc/BRIEF.md
# Eight-Channel Output Drive Controller with Flash and PWM

This block decides, cycle by cycle, whether each of eight output drivers is switched on. Software sets a static on/off pattern and can put any channel into a blinking mode. Blinking only happens on channels whose static bit is also set. One shared pulse-width generator can be steered onto any single channel, with a selectable active level. It overrides the static and blinking value on that channel only.

The blink wave for each group of four channels comes from one of two sources. It can follow an external blink clock, after synchronisation. It can also follow a power-of-two division of the system clock. Each group of four picks its own source and its own division.

A master enable, per-channel overcurrent flags and an over-temperature shutdown gate every channel's final drive. Overcurrent and the first over-temperature event can raise a sticky interrupt. If the over-temperature condition lasts long enough, all outputs are forced off until it clears.

Top module: `out_drive_ctrl`

## Requirements
- R1: After reset, drive_o is 0x00, irq_o is 0 and all registers are zero.
- R2: Writing the static pattern register (address 6) sets channel i on when bit i is 1 and out_en_i is 1. drive_o shows the new pattern on the second rising edge after the write cycle.
- R3: When out_en_i is 0 during a cycle, drive_o is 0x00 after the next rising edge.
- R4: The blink-enable register (address 7) makes channel i follow its group's blink wave only when static bit i is 1. A channel whose static bit is 0 stays off whatever its blink-enable bit is. In external mode the wave is flash_clk_i after two synchroniser stages.
- R5: The blink configuration register (address 3) holds one 4-bit field per group: bits [3:0] for channels 0-3 and bits [7:4] for channels 4-7. In each field, bit 3 set selects the system clock and bits [2:0] give an exponent e. The wave then toggles every 2^e cycles with 50% duty, and the two groups are independent.
- R6: The pulse control register (address 14) uses bits [2:0] for the target channel, bit 3 for polarity (1 = active high) and bit 4 for enable. When enabled, the target channel shows the pulse output instead of its static or blink value. All other channels are unaffected.
- R7: The pulse period is 4096 cycles. With active-high polarity the target channel is high for exactly 16 x V cycles per period, where V is the 8-bit value register at address 15.
- R8: With active-low polarity the channel is high for 4096 - 16 x V cycles per period. V = 0 gives a constant inactive level: constant low when active high, constant high when active low.
- R9: ovc_i bit i high forces channel i off after the next rising edge. A rising edge on any ovc_i bit sets the overcurrent interrupt only when bit 0 of the interrupt-enable register (address 4) is 1.
- R10: Interrupt flags are sticky and irq_o is their OR. Writing address 12 clears the overcurrent flag with data bit 0 and the temperature flag with data bit 1.
- R11: A rising edge on temp_hot_i sets the temperature warning flag when interrupt-enable bit 1 is 1. If temp_hot_i stays high for SHUT_DLY consecutive cycles, all outputs are forced off until temp_hot_i falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 8 | Register write data |
| out_en_i | input | 1 | Master output enable |
| flash_clk_i | input | 1 | External blink clock (asynchronous) |
| ovc_i | input | 8 | Per-channel overcurrent flags |
| temp_hot_i | input | 1 | Over-temperature indication |
| drive_o | output | 8 | Final per-channel drive |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench counts high cycles over whole periods of the pulse generator at small, full-scale and zero values, in both polarities. An off-by-one in the width or a wrong polarity sense would shift those counts away from 16 x V or its complement. It sets blink-enable on a channel whose static bit is clear and checks the channel stays dark. It measures toggle counts in two groups at different exponents, which a design that merged the groups or took the wrong counter bit would get wrong. It also checks that the interrupt survives removal of its cause until it is cleared, that a disabled source raises nothing, and that shutdown happens only after the dwell and releases once the temperature drops.

// File: rtl/odc_pkg.sv
package odc_pkg;

    localparam int DW     = 8;
    localparam int ADDR_W = 4;

    localparam logic [ADDR_W-1:0] A_FCFG = 4'd3;
    localparam logic [ADDR_W-1:0] A_IEN  = 4'd4;
    localparam logic [ADDR_W-1:0] A_OUT  = 4'd6;
    localparam logic [ADDR_W-1:0] A_FEN  = 4'd7;
    localparam logic [ADDR_W-1:0] A_CLR  = 4'd12;
    localparam logic [ADDR_W-1:0] A_PCTL = 4'd14;
    localparam logic [ADDR_W-1:0] A_PVAL = 4'd15;

    localparam int IRQ_OVC = 0;
    localparam int IRQ_TMP = 1;
    localparam int NIRQ    = 2;

    localparam int GRP     = 4;
    localparam int EXP_W   = 3;

    typedef struct packed {
        logic       en;
        logic       pol;
        logic [2:0] sel;
    } pctl_t;

    typedef struct packed {
        logic             sys;
        logic [EXP_W-1:0] expo;
    } grp_cfg_t;

endpackage

// File: rtl/odc_regs.sv
module odc_regs
    import odc_pkg::*;
#(
    parameter int NCH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DW-1:0]     wr_data,
    output logic [NCH-1:0]    stat_o,
    output logic [NCH-1:0]    fen_o,
    output logic [DW-1:0]     fcfg_o,
    output logic [NIRQ-1:0]   ien_o,
    output pctl_t             pctl_o,
    output logic [DW-1:0]     pval_o,
    output logic [NIRQ-1:0]   clr_o
);

    typedef struct packed {
        logic [NCH-1:0]  stat;
        logic [NCH-1:0]  fen;
        logic [DW-1:0]   fcfg;
        logic [NIRQ-1:0] ien;
        pctl_t           pctl;
        logic [DW-1:0]   pval;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (wr_en) begin
            case (wr_addr)
                A_OUT:   r_d.stat = wr_data[NCH-1:0];
                A_FEN:   r_d.fen  = wr_data[NCH-1:0];
                A_FCFG:  r_d.fcfg = wr_data;
                A_IEN:   r_d.ien  = wr_data[NIRQ-1:0];
                A_PCTL:  r_d.pctl = pctl_t'(wr_data[4:0]);
                A_PVAL:  r_d.pval = wr_data;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign stat_o = r_q.stat;
    assign fen_o  = r_q.fen;
    assign fcfg_o = r_q.fcfg;
    assign ien_o  = r_q.ien;
    assign pctl_o = r_q.pctl;
    assign pval_o = r_q.pval;
    assign clr_o  = (wr_en && wr_addr == A_CLR) ? wr_data[NIRQ-1:0] : '0;

endmodule

// File: rtl/odc_flash.sv
module odc_flash
    import odc_pkg::*;
#(
    parameter int NGRP = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flash_clk_i,
    input  logic [NGRP*GRP-1:0] fcfg_i,
    output logic [NGRP-1:0]   wave_o
);

    localparam int DIV_W = 1 << EXP_W;

    typedef struct packed {
        logic [1:0]       sync;
        logic [DIV_W-1:0] div;
    } fl_t;

    fl_t f_d, f_q;

    always_comb begin
        f_d      = f_q;
        f_d.sync = {f_q.sync[0], flash_clk_i};
        f_d.div  = f_q.div + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        grp_cfg_t cfg;
        assign cfg       = grp_cfg_t'(fcfg_i[g*GRP +: GRP]);
        assign wave_o[g] = cfg.sys ? f_q.div[cfg.expo] : f_q.sync[1];
    end

endmodule

// File: rtl/odc_pwm.sv
module odc_pwm
    import odc_pkg::*;
#(
    parameter int NCH   = 8,
    parameter int VAL_W = 8,
    parameter int PRE_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  pctl_t            pctl_i,
    input  logic [VAL_W-1:0] pval_i,
    output logic [NCH-1:0]   mask_o,
    output logic             level_o
);

    localparam int CNT_W = VAL_W + PRE_W;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } pw_t;

    pw_t p_d, p_q;
    logic active;

    always_comb begin
        p_d     = p_q;
        p_d.cnt = p_q.cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    assign active  = p_q.cnt[CNT_W-1:PRE_W] < pval_i;
    assign level_o = pctl_i.pol ? active : ~active;

    for (genvar c = 0; c < NCH; c++) begin : g_mask
        assign mask_o[c] = pctl_i.en && (32'(pctl_i.sel) == c);
    end

endmodule

// File: rtl/odc_fault.sv
module odc_fault
    import odc_pkg::*;
#(
    parameter int NCH      = 8,
    parameter int SHUT_DLY = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NCH-1:0]  ovc_i,
    input  logic            temp_hot_i,
    input  logic [NIRQ-1:0] ien_i,
    input  logic [NIRQ-1:0] clr_i,
    output logic            irq_o,
    output logic            shut_o
);

    localparam int CW = $clog2(SHUT_DLY);

    typedef struct packed {
        logic [NIRQ-1:0] pend;
        logic [NCH-1:0]  ovc_prev;
        logic            hot_prev;
        logic [CW-1:0]   hot_cnt;
        logic            shut;
    } ft_t;

    ft_t t_d, t_q;

    always_comb begin
        t_d          = t_q;
        t_d.ovc_prev = ovc_i;
        t_d.hot_prev = temp_hot_i;
        t_d.pend     = t_q.pend & ~clr_i;
        if (ien_i[IRQ_OVC] && |(ovc_i & ~t_q.ovc_prev))
            t_d.pend[IRQ_OVC] = 1'b1;
        if (ien_i[IRQ_TMP] && temp_hot_i && !t_q.hot_prev)
            t_d.pend[IRQ_TMP] = 1'b1;
        if (temp_hot_i) begin
            if (t_q.hot_cnt == CW'(SHUT_DLY - 1)) t_d.shut = 1'b1;
            else                                  t_d.hot_cnt = t_q.hot_cnt + 1'b1;
        end else begin
            t_d.hot_cnt = '0;
            t_d.shut    = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign irq_o  = |t_q.pend;
    assign shut_o = t_q.shut;

endmodule

// File: rtl/out_drive_ctrl.sv
module out_drive_ctrl
    import odc_pkg::*;
#(
    parameter int NCH      = 8,
    parameter int VAL_W    = 8,
    parameter int PRE_W    = 4,
    parameter int SHUT_DLY = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DW-1:0]     wr_data,
    input  logic              out_en_i,
    input  logic              flash_clk_i,
    input  logic [NCH-1:0]    ovc_i,
    input  logic              temp_hot_i,
    output logic [NCH-1:0]    drive_o,
    output logic              irq_o
);

    localparam int NGRP = NCH / GRP;

    logic [NCH-1:0]  stat_bits, fen_bits, pwm_mask, base, src;
    logic [DW-1:0]   fcfg;
    logic [NIRQ-1:0] ien, clr;
    pctl_t           pctl;
    logic [DW-1:0]   pval;
    logic [NGRP-1:0] wave;
    logic            pwm_level, shut;

    odc_regs #(.NCH(NCH)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .stat_o(stat_bits), .fen_o(fen_bits), .fcfg_o(fcfg), .ien_o(ien),
        .pctl_o(pctl), .pval_o(pval), .clr_o(clr)
    );

    odc_flash #(.NGRP(NGRP)) u_flash (
        .clk(clk), .rst_n(rst_n), .flash_clk_i(flash_clk_i),
        .fcfg_i(fcfg[NGRP*GRP-1:0]), .wave_o(wave)
    );

    odc_pwm #(.NCH(NCH), .VAL_W(VAL_W), .PRE_W(PRE_W)) u_pwm (
        .clk(clk), .rst_n(rst_n), .pctl_i(pctl), .pval_i(pval[VAL_W-1:0]),
        .mask_o(pwm_mask), .level_o(pwm_level)
    );

    odc_fault #(.NCH(NCH), .SHUT_DLY(SHUT_DLY)) u_fault (
        .clk(clk), .rst_n(rst_n), .ovc_i(ovc_i), .temp_hot_i(temp_hot_i),
        .ien_i(ien), .clr_i(clr), .irq_o(irq_o), .shut_o(shut)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        assign base[c] = stat_bits[c] & (fen_bits[c] ? wave[c / GRP] : 1'b1);
        assign src[c]  = pwm_mask[c] ? pwm_level : base[c];
    end

    typedef struct packed {
        logic [NCH-1:0] drive;
    } top_t;

    top_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        s_d.drive = src & ~ovc_i & {NCH{out_en_i & ~shut}};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign drive_o = s_q.drive;

endmodule

// File: rtl/odc_checker.sv
module odc_checker
    import odc_pkg::*;
#(
    parameter int NCH = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              out_en_i,
    input logic [NCH-1:0]    ovc_i,
    input logic [NCH-1:0]    drive_o,
    input logic              irq_o,
    input logic              shut,
    input logic [NCH-1:0]    stat_bits,
    input logic [NCH-1:0]    pwm_mask
);

    logic clr_wr;
    assign clr_wr = wr_en && (wr_addr == A_CLR);

    AST_MASTER_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        !out_en_i |=> (drive_o == '0)); // R3

    AST_OVC_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (|ovc_i) |=> ((drive_o & $past(ovc_i)) == '0)); // R9

    AST_SHUT_ALL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        shut |=> (drive_o == '0)); // R11

    AST_DRIVE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        (|drive_o) |-> ((drive_o & ~$past(stat_bits) & ~$past(pwm_mask)) == '0)); // R4

    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !clr_wr) |=> irq_o); // R10

endmodule

bind out_drive_ctrl odc_checker #(.NCH(NCH)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .out_en_i(out_en_i), .ovc_i(ovc_i), .drive_o(drive_o), .irq_o(irq_o),
    .shut(shut), .stat_bits(stat_bits), .pwm_mask(pwm_mask)
);

// File: tb/sim_out_drive_ctrl.sv
`timescale 1ns/1ps
module sim_out_drive_ctrl;

    localparam int SHUT_DLY = 64;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [3:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       out_en_i = 1'b0;
    logic       flash_clk_i = 1'b0;
    logic [7:0] ovc_i = '0;
    logic       temp_hot_i = 1'b0;
    logic [7:0] drive_o;
    logic       irq_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    out_drive_ctrl #(.SHUT_DLY(SHUT_DLY)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .out_en_i(out_en_i), .flash_clk_i(flash_clk_i), .ovc_i(ovc_i),
        .temp_hot_i(temp_hot_i), .drive_o(drive_o), .irq_o(irq_o)
    );

    task automatic chk(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            failures++;
            $display("FAIL %s got=%0d (0x%0h) expected=%0d (0x%0h)", tag, got, got, exp, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Samples n cycles: high count and toggle count of channel ch,
    // plus the number of samples where any bit in quiet is set.
    task automatic run(input int n, input int ch, input logic [7:0] quiet,
                       output int hi, output int tog, output int stray);
        logic prev;
        hi = 0; tog = 0; stray = 0;
        prev = drive_o[ch];
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (drive_o[ch]) hi++;
            if (drive_o[ch] != prev) tog++;
            if ((drive_o & quiet) != 8'h00) stray++;
            prev = drive_o[ch];
        end
    endtask

    task automatic t_reset();
        chk("R1 drive after reset", int'(drive_o), 0);
        chk("R1 irq after reset", int'(irq_o), 0);
    endtask

    task automatic t_static();
        out_en_i = 1'b1;
        wr(4'd6, 8'hA5); settle(1);
        chk("R2 static A5", int'(drive_o), 'hA5);
        wr(4'd6, 8'h3C); settle(1);
        chk("R2 static 3C", int'(drive_o), 'h3C);
    endtask

    task automatic t_master();
        out_en_i = 1'b0; settle(1);
        chk("R3 master off", int'(drive_o), 0);
        out_en_i = 1'b1; settle(1);
        chk("R3 master back on", int'(drive_o), 'h3C);
    endtask

    task automatic t_flash_ext();
        wr(4'd3, 8'h00);
        wr(4'd6, 8'h0F);
        wr(4'd7, 8'h13);
        flash_clk_i = 1'b0; settle(5);
        chk("R4 ext flash low phase", int'(drive_o), 'h0C);
        flash_clk_i = 1'b1; settle(5);
        chk("R4 ext flash high phase, ch4 static 0 stays off", int'(drive_o), 'h0F);
        flash_clk_i = 1'b0; settle(5);
        chk("R4 ext flash low again", int'(drive_o), 'h0C);
    endtask

    task automatic t_flash_sys();
        int hi, tog, stray;
        wr(4'd7, 8'h00);
        wr(4'd6, 8'h11);
        wr(4'd7, 8'h11);
        wr(4'd3, 8'hB9);
        settle(2);
        run(256, 0, 8'hEE, hi, tog, stray);
        chk("R5 low group e=1 toggles", tog, 128);
        chk("R5 low group duty", hi, 128);
        chk("R5 unflashed channels dark", stray, 0);
        run(256, 4, 8'h00, hi, tog, stray);
        chk("R5 high group e=3 toggles", tog, 32);
        chk("R5 high group duty", hi, 128);
    endtask

    task automatic t_pwm();
        int hi, tog, stray;
        wr(4'd7, 8'h00);
        wr(4'd3, 8'h00);
        wr(4'd6, 8'hFF);
        wr(4'd15, 8'h00);
        wr(4'd14, 8'h1A);
        settle(2);
        chk("R8 value 0 active high constant low on ch2 only", int'(drive_o), 'hFB);
        wr(4'd14, 8'h12);
        settle(2);
        chk("R8 value 0 active low constant high", int'(drive_o), 'hFF);
        wr(4'd6, 8'h00);
        wr(4'd15, 8'd5);
        wr(4'd14, 8'h1A);
        settle(2);
        run(4096, 2, 8'hFB, hi, tog, stray);
        chk("R7 width 5x16", hi, 80);
        chk("R6 other channels untouched", stray, 0);
        wr(4'd14, 8'h12);
        settle(2);
        run(4096, 2, 8'hFB, hi, tog, stray);
        chk("R8 active low width", hi, 4096 - 80);
        wr(4'd15, 8'd255);
        wr(4'd14, 8'h1D);
        settle(2);
        run(4096, 5, 8'hDF, hi, tog, stray);
        chk("R7 full scale on ch5", hi, 4080);
        chk("R6 ch5 target only", stray, 0);
        wr(4'd14, 8'h00);
    endtask

    task automatic t_ovc();
        wr(4'd6, 8'hFF);
        wr(4'd4, 8'h01);
        settle(1);
        ovc_i = 8'h08; settle(1);
        chk("R9 overcurrent channel off", int'(drive_o), 'hF7);
        chk("R9 overcurrent irq", int'(irq_o), 1);
        ovc_i = 8'h00; settle(3);
        chk("R9 channel back after ovc drops", int'(drive_o), 'hFF);
        chk("R10 irq sticky", int'(irq_o), 1);
        wr(4'd12, 8'h01); settle(1);
        chk("R10 irq cleared", int'(irq_o), 0);
        wr(4'd4, 8'h00);
        ovc_i = 8'h40; settle(2);
        chk("R9 disabled report no irq", int'(irq_o), 0);
        ovc_i = 8'h00; settle(1);
    endtask

    task automatic t_temp();
        wr(4'd4, 8'h02);
        temp_hot_i = 1'b1; settle(1);
        chk("R11 warning irq", int'(irq_o), 1);
        settle(SHUT_DLY - 8);
        chk("R11 outputs on before dwell", int'(drive_o), 'hFF);
        settle(12);
        chk("R11 shutdown after dwell", int'(drive_o), 0);
        temp_hot_i = 1'b0; settle(3);
        chk("R11 release after cooling", int'(drive_o), 'hFF);
        wr(4'd12, 8'h02); settle(1);
        chk("R10 temp flag cleared", int'(irq_o), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        settle(1);
        t_reset();
        t_static();
        t_master();
        t_flash_ext();
        t_flash_sys();
        t_pwm();
        t_ovc();
        t_temp();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule